// File: doc/BRIEF.md
# Audio DMA serial output engine

This block plays stereo audio out of system memory with no processor help once a buffer has been handed over. Software programs a start address and then a byte count. The length write turns that pair into a queued buffer. Up to two buffers can wait: the one being played and the one after it. When DMA is enabled, the block reads 32-bit sample words through a single request/acknowledge read port. It fetches one word per sample frame and sends each frame out on a serial bit clock, a word-select line and a data line. The bit clock and the frame rate both come from the system clock through two separate programmable dividers.

The fetch side is a three-state machine. F_IDLE moves to F_REQ when DMA is enabled and a buffer is active. F_REQ holds the request until the memory acknowledges it, then moves to F_HOLD. F_HOLD keeps the fetched word until the frame tick takes it, then returns to F_IDLE.

The serial side is also a three-state machine. S_IDLE moves to S_ARM on a frame tick. S_ARM moves to S_SHIFT on the next falling edge of the bit clock. S_SHIFT returns to S_IDLE after its 32nd bit, or goes back to S_ARM if a new tick arrives first. The interrupt output is raised when the queue stops being full, and any write to the status register clears it.

Top module: `audio_stream_out`

## Requirements
- R1: Register select 0 takes a start address, with bits [2:0] forced to zero. Select 0 reads back the current fetch address of the active buffer, or the last written aligned address when the queue is empty.
- R2: A write to select 1 queues one buffer made of the held address and the written byte count, with the count's bits [2:0] forced to zero. A count that becomes zero queues nothing. Select 1 reads the remaining byte count of the active buffer, or 0 when the queue is empty.
- R3: The queue holds at most two buffers. A length write while both are held is dropped. Buffers play in the order they were written, and the waiting one is promoted when the active one is used up.
- R4: Bit 0 of select 2 enables DMA. While it is 0, no new memory request starts. Select 2 reads back the bit.
- R5: Select 3 reads bit 31 = queue full, bit 30 = busy (DMA enabled and a buffer active), and bit 0 = a copy of bit 31. All other bits read 0.
- R6: The irq output goes high in the cycle after the full flag falls from 1 to 0. A write of any value to select 3 clears it. It does not rise when a buffer ends while the queue is not full.
- R7: With a 14-bit period P at select 4 (reset value 16383), a frame starts every P+1 system clocks.
- R8: With a 4-bit value H at select 5 (reset value 15), the bit clock stays high, and stays low, for H+1 system clocks each. H = 0 holds the bit clock low.
- R9: Each frame sends the 32-bit word MSB first: the upper 16 bits (left) while word select is 0, then the lower 16 bits (right) while word select is 1. Data changes after falling edges of the bit clock, is stable at rising edges, and word select idles at 1.
- R10: When no fetched word is waiting, the frame repeats the last sample played. With the queue empty, busy reads 0 and no memory request is made.
- R11: Every memory request reads one 32-bit word. The request and its address stay unchanged until acknowledged, and the address steps by 4 bytes through the buffer.
- R12: After reset the register reads are: control 0, status 0, length 0, period 16383, bit clock 15. The irq and the memory request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0..5) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Byte address of the requested word |
| mem_ack | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Memory response word |
| aud_bclk | output | 1 | Serial bit clock |
| aud_ws | output | 1 | Word select, 0 left, 1 right |
| aud_sdata | output | 1 | Serial data, MSB first |
| irq | output | 1 | Pending interrupt |

## Verification
The bench builds the block with its default widths: 24-bit address, 18-bit length, 14-bit period, 4-bit half period and 32-bit samples. It then programs short legal rates, P = 131 with H = 1 and later P = 197 with H = 2. These make frames of 132 and 198 clocks, so dozens of complete frames fit in a short run. Both frame lengths are whole multiples of the bit-clock period, so frame starts repeat at an exact interval that the bench can measure. The 18-bit length lets tiny buffers of two to six words reach queue-full, promotion, the interrupt and the repeat-on-underrun case within a few frames.

// File: rtl/aso_pkg.sv
package aso_pkg;

    typedef enum logic [1:0] {
        F_IDLE,
        F_REQ,
        F_HOLD
    } fetch_state_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ARM,
        S_SHIFT
    } shift_state_t;

    localparam logic [2:0] RSEL_ADDR = 3'd0;
    localparam logic [2:0] RSEL_LEN  = 3'd1;
    localparam logic [2:0] RSEL_CTRL = 3'd2;
    localparam logic [2:0] RSEL_STAT = 3'd3;
    localparam logic [2:0] RSEL_PER  = 3'd4;
    localparam logic [2:0] RSEL_BCK  = 3'd5;

endpackage

// File: rtl/aso_clkgen.sv
module aso_clkgen #(
    parameter int PER_W  = 14,
    parameter int HALF_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PER_W-1:0]  period,
    input  logic [HALF_W-1:0] half,
    output logic              frame_tick,
    output logic              bclk,
    output logic              bclk_fall
);

    logic [PER_W-1:0]  per_cnt;
    logic [HALF_W-1:0] half_cnt;
    logic              half_wrap;

    assign frame_tick = (per_cnt >= period);
    assign half_wrap  = (half != '0) && (half_cnt >= half);
    assign bclk_fall  = half_wrap && bclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_cnt <= '0;
        end else if (frame_tick) begin
            per_cnt <= '0;
        end else begin
            per_cnt <= per_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_cnt <= '0;
            bclk     <= 1'b0;
        end else if (half == '0) begin
            half_cnt <= '0;
            bclk     <= 1'b0;
        end else if (half_wrap) begin
            half_cnt <= '0;
            bclk     <= ~bclk;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    assert_clk_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (half == '0) |=> !bclk);

    assert_fall_only_high_R8: assert property (@(posedge clk) disable iff (rst)
        bclk_fall |=> !bclk);

endmodule

// File: rtl/aso_dma.sv
module aso_dma
    import aso_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int LEN_W    = 18,
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dma_en,
    input  logic                addr_wr,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic                len_wr,
    input  logic [LEN_W-1:0]    len_in,
    input  logic                frame_tick,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ack,
    input  logic [SAMPLE_W-1:0] mem_rdata,
    output logic [SAMPLE_W-1:0] sample,
    output logic                full,
    output logic                busy,
    output logic [ADDR_W-1:0]   cur_addr,
    output logic [LEN_W-1:0]    cur_len
);

    localparam int BYTES = SAMPLE_W / 8;

    fetch_state_t fst, fst_nx;

    logic                held_valid_unused;
    logic [ADDR_W-1:0]   held_addr;
    logic                a_valid, n_valid;
    logic [ADDR_W-1:0]   a_addr, n_addr;
    logic [LEN_W-1:0]    a_len, n_len;
    logic [SAMPLE_W-1:0] word_q;
    logic                ack_fire, last_word, commit, a_after, n_after;

    assign held_valid_unused = 1'b0;
    assign ack_fire  = (fst == F_REQ) && mem_ack;
    assign last_word = ack_fire && (a_len == LEN_W'(BYTES));
    assign commit    = len_wr && (len_in != '0);
    assign a_after   = a_valid && !(last_word && !n_valid);
    assign n_after   = n_valid && !last_word;

    always_comb begin
        fst_nx = fst;
        unique case (fst)
            F_IDLE: if (dma_en && a_valid) fst_nx = F_REQ;
            F_REQ:  if (mem_ack)           fst_nx = F_HOLD;
            F_HOLD: if (frame_tick)        fst_nx = F_IDLE;
            default:                       fst_nx = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) fst <= F_IDLE;
        else     fst <= fst_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_addr <= '0;
            a_valid   <= 1'b0;
            n_valid   <= 1'b0;
            a_addr    <= '0;
            n_addr    <= '0;
            a_len     <= '0;
            n_len     <= '0;
            word_q    <= '0;
        end else begin
            if (addr_wr) held_addr <= addr_in;
            if (ack_fire) begin
                word_q <= mem_rdata;
                if (last_word) begin
                    a_valid <= n_valid;
                    a_addr  <= n_addr;
                    a_len   <= n_len;
                    n_valid <= 1'b0;
                end else begin
                    a_addr <= a_addr + ADDR_W'(BYTES);
                    a_len  <= a_len - LEN_W'(BYTES);
                end
            end
            if (commit) begin
                if (!a_after) begin
                    a_valid <= 1'b1;
                    a_addr  <= held_addr;
                    a_len   <= len_in;
                end else if (!n_after) begin
                    n_valid <= 1'b1;
                    n_addr  <= held_addr;
                    n_len   <= len_in;
                end
            end
        end
    end

    always_comb begin
        mem_req  = (fst == F_REQ);
        mem_addr = a_addr;
        sample   = word_q;
        full     = a_valid && n_valid;
        busy     = a_valid && dma_en;
        cur_addr = a_valid ? a_addr : held_addr;
        cur_len  = a_valid ? a_len : '0;
    end

    assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req);

    assert_addr_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    assert_req_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> dma_en);

    assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (rst)
        (full && commit && !ack_fire) |=> (n_addr == $past(n_addr) && n_len == $past(n_len)));

endmodule

// File: rtl/aso_shifter.sv
module aso_shifter
    import aso_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_tick,
    input  logic         bclk_fall,
    input  logic [W-1:0] sample,
    output logic         sdata,
    output logic         ws
);

    localparam int CNT_W = $clog2(W);

    shift_state_t st, st_nx;
    logic [W-1:0]     pend, shreg;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (frame_tick) st_nx = S_ARM;
            S_ARM:   if (frame_tick) st_nx = S_ARM;
                     else if (bclk_fall) st_nx = S_SHIFT;
            S_SHIFT: if (frame_tick) st_nx = S_ARM;
                     else if (bclk_fall && cnt == CNT_W'(W-1)) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            shreg <= '0;
            cnt   <= '0;
        end else begin
            if (frame_tick) pend <= sample;
            if (!frame_tick && bclk_fall) begin
                if (st == S_ARM) begin
                    shreg <= pend;
                    cnt   <= '0;
                end else if (st == S_SHIFT && cnt != CNT_W'(W-1)) begin
                    shreg <= shreg << 1;
                    cnt   <= cnt + 1'b1;
                end
            end
        end
    end

    always_comb begin
        sdata = shreg[W-1];
        ws    = (st == S_SHIFT) ? (cnt >= CNT_W'(W/2)) : 1'b1;
    end

    assert_ws_mid_frame_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(ws) && st == S_SHIFT) |-> (cnt == CNT_W'(W/2)));

    assert_shift_starts_left_R9: assert property (@(posedge clk) disable iff (rst)
        (st == S_ARM && bclk_fall && !frame_tick) |=> !ws);

endmodule

// File: rtl/audio_stream_out.sv
module audio_stream_out
    import aso_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int LEN_W    = 18,
    parameter int PER_W    = 14,
    parameter int HALF_W   = 4,
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [2:0]          reg_sel,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ack,
    input  logic [SAMPLE_W-1:0] mem_rdata,
    output logic                aud_bclk,
    output logic                aud_ws,
    output logic                aud_sdata,
    output logic                irq
);

    logic                ctrl_en;
    logic [PER_W-1:0]    period_q;
    logic [HALF_W-1:0]   half_q;
    logic                full, busy, full_d;
    logic [ADDR_W-1:0]   cur_addr, addr_aligned;
    logic [LEN_W-1:0]    cur_len, len_aligned;
    logic [SAMPLE_W-1:0] sample;
    logic                frame_tick, bclk_fall;
    logic                wr_addr, wr_len, wr_stat;
    logic                unused_wbits;

    assign addr_aligned = {reg_wdata[ADDR_W-1:3], 3'b000};
    assign len_aligned  = {reg_wdata[LEN_W-1:3], 3'b000};
    assign wr_addr      = reg_wr && (reg_sel == RSEL_ADDR);
    assign wr_len       = reg_wr && (reg_sel == RSEL_LEN);
    assign wr_stat      = reg_wr && (reg_sel == RSEL_STAT);
    assign unused_wbits = ^{reg_wdata[31:ADDR_W], reg_wdata[2:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en  <= 1'b0;
            period_q <= '1;
            half_q   <= '1;
            full_d   <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (reg_wr && reg_sel == RSEL_CTRL) ctrl_en  <= reg_wdata[0];
            if (reg_wr && reg_sel == RSEL_PER)  period_q <= reg_wdata[PER_W-1:0];
            if (reg_wr && reg_sel == RSEL_BCK)  half_q   <= reg_wdata[HALF_W-1:0];
            full_d <= full;
            if (full_d && !full) irq <= 1'b1;
            else if (wr_stat)    irq <= 1'b0;
        end
    end

    always_comb begin
        case (reg_sel)
            RSEL_ADDR: reg_rdata = 32'(cur_addr);
            RSEL_LEN:  reg_rdata = 32'(cur_len);
            RSEL_CTRL: reg_rdata = {31'b0, ctrl_en};
            RSEL_STAT: reg_rdata = {full, busy, 29'b0, full};
            RSEL_PER:  reg_rdata = 32'(period_q);
            RSEL_BCK:  reg_rdata = 32'(half_q);
            default:   reg_rdata = '0;
        endcase
    end

    aso_dma #(
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .SAMPLE_W (SAMPLE_W)
    ) dma_u (
        .clk        (clk),
        .rst        (rst),
        .dma_en     (ctrl_en),
        .addr_wr    (wr_addr),
        .addr_in    (addr_aligned),
        .len_wr     (wr_len),
        .len_in     (len_aligned),
        .frame_tick (frame_tick),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .sample     (sample),
        .full       (full),
        .busy       (busy),
        .cur_addr   (cur_addr),
        .cur_len    (cur_len)
    );

    aso_clkgen #(
        .PER_W  (PER_W),
        .HALF_W (HALF_W)
    ) clk_u (
        .clk        (clk),
        .rst        (rst),
        .period     (period_q),
        .half       (half_q),
        .frame_tick (frame_tick),
        .bclk       (aud_bclk),
        .bclk_fall  (bclk_fall)
    );

    aso_shifter #(
        .W (SAMPLE_W)
    ) shf_u (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .bclk_fall  (bclk_fall),
        .sample     (sample),
        .sdata      (aud_sdata),
        .ws         (aud_ws)
    );

    assert_irq_on_full_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(full) |=> irq);

    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !$fell(full)) |=> !irq);

    assert_busy_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> ctrl_en);

endmodule

// File: tb/audio_stream_out_tb.sv
module audio_stream_out_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        aud_bclk, aud_ws, aud_sdata, irq;

    always #4 clk = ~clk;

    audio_stream_out dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .aud_bclk  (aud_bclk),
        .aud_ws    (aud_ws),
        .aud_sdata (aud_sdata),
        .irq       (irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    int cyc = 0;
    int reqs = 0;
    int bad_reqs = 0;
    bit nofetch = 0;
    int frames = 0;
    int repeats = 0;
    int ws_err = 0;
    int last_iv = 0;
    int last_start = 0;
    int hi_start = 0;
    int last_hi = 0;
    int nbits = -1;
    logic [31:0] fw = 32'd0;
    logic [31:0] last_out = 32'd0;
    logic pb = 1'b0;
    logic pws = 1'b1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [23:0] a);
        return {a[15:0] ^ 16'h5A3C, a[7:0] + 8'h11, a[23:16] ^ 8'h96};
    endfunction

    // driver side of the scoreboard: words a buffer should produce (R3, R11)
    task automatic queue_expect(input logic [23:0] a, input int bytes);
        for (int k = 0; k < bytes / 4; k++) exp_q.push_back(mem_word(a + 24'(4 * k)));
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_drain(input string req);
        int t = 0;
        while (exp_q.size() != 0 && t < 6000) begin
            @(negedge clk);
            t++;
        end
        chk(req, 32'(exp_q.size()), 32'd0);
    endtask

    task automatic wait_frames(input int n);
        int f0 = frames;
        int t = 0;
        while (frames < f0 + n && t < 8000) begin
            @(negedge clk);
            t++;
        end
    endtask

    always @(posedge clk) cyc++;

    // memory model: one-cycle acknowledge (R11)
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   = 1'b1;
            mem_rdata = mem_word(mem_addr);
            reqs++;
            if (nofetch) bad_reqs++;
        end else begin
            mem_ack = 1'b0;
        end
    end

    // monitor: sample at bit-clock rises, rebuild frames, compare (R9, R10)
    always @(negedge clk) begin
        if (aud_bclk && !pb) begin
            hi_start = cyc;
            if (!aud_ws && pws) begin
                if (last_start != 0) last_iv = cyc - last_start;
                last_start = cyc;
                nbits = 0;
                fw = 32'd0;
            end
            if (nbits >= 0) begin
                if (aud_ws !== (nbits >= 16)) ws_err++;
                fw = {fw[30:0], aud_sdata};
                nbits++;
                if (nbits == 32) begin
                    nbits = -1;
                    frames++;
                    n_chk++;
                    if (exp_q.size() > 0 && fw == exp_q[0]) begin
                        void'(exp_q.pop_front());
                    end else if (fw == last_out) begin
                        repeats++;
                    end else begin
                        n_bad++;
                        $display("FAIL R9/R11 frame actual=%h expected=%h", fw,
                                 (exp_q.size() > 0) ? exp_q[0] : last_out);
                    end
                    last_out = fw;
                end
            end
            pws = aud_ws;
        end
        if (!aud_bclk && pb) last_hi = cyc - hi_start;
        pb = aud_bclk;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int r0, rep0, tcount;
        wait_cycles(5);
        rst = 1'b0;
        wait_cycles(2);

        // R12: reset state
        rd(3'd3, d); chk("R12 status", d, 32'h0);
        rd(3'd2, d); chk("R12 control", d, 32'h0);
        rd(3'd1, d); chk("R12 length", d, 32'h0);
        rd(3'd4, d); chk("R12 period", d, 32'd16383);
        rd(3'd5, d); chk("R12 bitclk", d, 32'd15);
        chk("R12 irq", 32'(irq), 32'd0);
        chk("R12 mem_req", 32'(mem_req), 32'd0);

        wr(3'd4, 32'd131);
        wr(3'd5, 32'd1);
        nofetch = 1;

        // R1: address alignment, held value visible with empty queue
        wr(3'd0, 32'h0000_0105);
        rd(3'd0, d); chk("R1 aligned held address", d, 32'h100);
        // R2: zero count queues nothing
        wr(3'd1, 32'd0);
        rd(3'd1, d); chk("R2 zero length ignored", d, 32'd0);
        rd(3'd3, d); chk("R2 zero length status", d, 32'h0);
        // R2: low bits of count ignored
        wr(3'd1, 32'd19);
        queue_expect(24'h100, 16);
        rd(3'd1, d); chk("R2 length aligned", d, 32'd16);
        rd(3'd0, d); chk("R1 active address", d, 32'h100);
        rd(3'd3, d); chk("R5 one entry, disabled", d, 32'h0);
        // R3/R5: second entry fills the queue
        wr(3'd0, 32'h200);
        wr(3'd1, 32'd8);
        queue_expect(24'h200, 8);
        rd(3'd3, d); chk("R5 full flag bits 31 and 0", d, 32'h8000_0001);
        // R3: third entry dropped
        wr(3'd0, 32'h300);
        wr(3'd1, 32'd8);
        rd(3'd1, d); chk("R3 dropped write keeps length", d, 32'd16);
        rd(3'd0, d); chk("R3 dropped write keeps address", d, 32'h100);
        wait_cycles(400);
        chk("R4 no fetch while disabled", 32'(bad_reqs), 32'd0);
        chk("R4 no request count", 32'(reqs), 32'd0);
        nofetch = 0;

        // R4/R5: enable
        wr(3'd2, 32'h1);
        rd(3'd2, d); chk("R4 control readback", d, 32'h1);
        rd(3'd3, d); chk("R5 full and busy", d, 32'hC000_0001);
        wait_drain("R3 both buffers played in order");
        chk("R6 irq after full falls", 32'(irq), 32'd1);
        wr(3'd3, 32'h0);
        chk("R6 irq cleared by status write", 32'(irq), 32'd0);
        rd(3'd3, d); chk("R10 idle status", d, 32'h0);
        rd(3'd1, d); chk("R1 length reads 0 when empty", d, 32'd0);

        // R10: underrun repeats last sample, no requests
        r0 = reqs; rep0 = repeats;
        wait_frames(3);
        chk("R10 no requests when empty", 32'(reqs - r0), 32'd0);
        chk("R10 repeated frames", 32'(repeats - rep0 >= 2), 32'd1);
        chk("R7 frame interval 132", 32'(last_iv), 32'd132);
        chk("R8 bit clock high 2", 32'(last_hi), 32'd2);

        // second rate set, changed right after a frame completes
        wait_frames(1);
        wr(3'd4, 32'd197);
        wr(3'd5, 32'd2);
        wr(3'd0, 32'h1000);
        wr(3'd1, 32'd24);
        queue_expect(24'h1000, 24);
        wait_drain("R11 six-word buffer");
        wait_frames(3);
        chk("R7 frame interval 198", 32'(last_iv), 32'd198);
        chk("R8 bit clock high 3", 32'(last_hi), 32'd3);
        chk("R6 no irq without full", 32'(irq), 32'd0);
        chk("R9 word select pattern", 32'(ws_err), 32'd0);

        // R8: zero stops the bit clock
        wr(3'd5, 32'd0);
        wait_cycles(10);
        tcount = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (aud_bclk) tcount++;
        end
        chk("R8 bit clock held low", 32'(tcount), 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule